// File: doc/BRIEF.md
# Address-Range Memory Access Router

This block steers bus accesses toward one of several memory regions, or toward a register path that serves everything else. Each region has a compile-time window of word addresses, given by an inclusive low and high bound, and a two-bit access code. The read side and the write side are decoded separately. The read word address picks the region that answers a read. The write word address picks the region that takes a write.

Regions are tested in index order. The lowest-indexed region whose window holds the address is the one that answers. That region's done and error flags, and its read data for reads, are passed back to the bus, and its select line is raised. An address that no window holds gets the register path's response without change. An access to a region that lacks the needed permission does not stall. It completes at once with an error that follows the current strobe. The block has no state: every output is a pure function of its inputs.

Each region also receives a local memory address. This is the low part of the word address, with as many bits as the base-2 logarithm of the region's size.

Top module: `mem_region_router`

## Requirements
- R1: A region's window holds a word address w when RGN_LO[i] <= w <= RGN_HI[i], with both bounds inclusive. Default windows: region 0 holds words 64..127, region 1 holds 96..159, region 2 holds 256..271.
- R2: When several windows hold the same address, the lowest region index wins. Words 96..127 go to region 0.
- R3: At most one bit of `rgn_rd_sel_o` and at most one bit of `rgn_wr_sel_o` is 1. A bit is 1 only for the winning region, and only if that region has the matching permission. Access code bit 0 means readable and bit 1 means writable. Defaults: region 0 is 2'b11, region 1 is 2'b01, region 2 is 2'b10.
- R4: When a readable region wins the read address, `rd_data_o`, `rd_done_o` and `rd_err_o` equal that region's read data, done and error inputs.
- R5: When a region without read permission wins the read address, `rd_data_o` is 0, `rd_done_o` is 0 and `rd_err_o` equals `rd_stb_i`.
- R6: When a writable region wins the write address, `wr_done_o` and `wr_err_o` equal that region's write done and error inputs.
- R7: When a region without write permission wins the write address, `wr_done_o` is 0 and `wr_err_o` equals `wr_stb_i`.
- R8: When no window holds the address, the read outputs equal `reg_rd_data_i`, `reg_rd_done_i` and `reg_rd_err_i`, and the write outputs equal `reg_wr_done_i` and `reg_wr_err_i`.
- R9: Read routing depends only on `rd_word_i`. Write routing depends only on `wr_word_i`.
- R10: Field i of `rgn_rd_addr_o` and of `rgn_wr_addr_o` sits at bits [i*MEM_AW +: MEM_AW]. It holds the low clog2(RGN_HI-RGN_LO+1) bits of the read or write word, zero-extended to MEM_AW. With the defaults, MEM_AW is 6 and the widths are 6, 6 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_word_i | input | WA_W | Read word address |
| rd_stb_i | input | 1 | Read strobe |
| wr_word_i | input | WA_W | Write word address |
| wr_stb_i | input | 1 | Write strobe |
| rgn_rd_data_i | input | N_RGN*DATA_W | Read data from each region |
| rgn_rd_done_i | input | N_RGN | Read done from each region |
| rgn_rd_err_i | input | N_RGN | Read error from each region |
| rgn_wr_done_i | input | N_RGN | Write done from each region |
| rgn_wr_err_i | input | N_RGN | Write error from each region |
| reg_rd_data_i | input | DATA_W | Register path read data |
| reg_rd_done_i | input | 1 | Register path read done |
| reg_rd_err_i | input | 1 | Register path read error |
| reg_wr_done_i | input | 1 | Register path write done |
| reg_wr_err_i | input | 1 | Register path write error |
| rd_data_o | output | DATA_W | Routed read data |
| rd_done_o | output | 1 | Routed read done |
| rd_err_o | output | 1 | Routed read error |
| wr_done_o | output | 1 | Routed write done |
| wr_err_o | output | 1 | Routed write error |
| rgn_rd_sel_o | output | N_RGN | Read select for each region |
| rgn_wr_sel_o | output | N_RGN | Write select for each region |
| rgn_rd_addr_o | output | N_RGN*MEM_AW | Local read address for each region |
| rgn_wr_addr_o | output | N_RGN*MEM_AW | Local write address for each region |

## Verification
The bench sweeps every read word and drives a write word at a fixed offset from it, so the two sides are always decoded from different addresses. It varies the strobes and the region and register responses on every vector. This catches four kinds of fault:
- Off-by-one bounds, which misroute words 63, 64, 127, 128, 159 or 271.
- An inverted priority, which hands the overlap 96..127 to the read-only region.
- A permission-error path tied to a constant instead of the strobe, which shows up as a wrong `rd_err_o` or `wr_err_o` on denied accesses.
- A swapped address source, which changes the selects at words where only one side hits.

// File: rtl/mr_pkg.sv
package mr_pkg;

    // Access permission code: bit 0 allows reads, bit 1 allows writes.
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RO   = 2'b01,
        ACC_WO   = 2'b10,
        ACC_RW   = 2'b11
    } mr_acc_e;

    localparam int unsigned LANE_RD = 0;
    localparam int unsigned LANE_WR = 1;

    // Flags returned by one side of the router.
    typedef struct packed {
        logic done;
        logic err;
    } mr_resp_t;

    // Bits needed to index a window of inclusive bounds lo..hi.
    function automatic int unsigned span_bits(int unsigned lo, int unsigned hi);
        int unsigned sz;
        sz = hi - lo + 1;
        return (sz <= 1) ? 1 : $clog2(sz);
    endfunction

endpackage

// File: rtl/mr_range_match.sv
module mr_range_match #(
    parameter int unsigned N_RGN = 3,
    parameter int unsigned WA_W  = 10,
    parameter logic [N_RGN*WA_W-1:0] RGN_LO = '0,
    parameter logic [N_RGN*WA_W-1:0] RGN_HI = '0
) (
    input  logic [WA_W-1:0]  word_i,
    output logic [N_RGN-1:0] hit_o
);
    for (genvar g = 0; g < N_RGN; g++) begin : g_cmp
        localparam logic [WA_W-1:0] LO = RGN_LO[g*WA_W +: WA_W];
        localparam logic [WA_W-1:0] HI = RGN_HI[g*WA_W +: WA_W];
        assign hit_o[g] = (word_i >= LO) && (word_i <= HI);
    end
endmodule

// File: rtl/mr_first_pick.sv
module mr_first_pick #(
    parameter int unsigned N_RGN = 3
) (
    input  logic [N_RGN-1:0] hit_i,
    output logic [N_RGN-1:0] pick_o,
    output logic             any_o
);
    always_comb begin
        pick_o = '0;
        any_o  = 1'b0;
        for (int i = 0; i < N_RGN; i++) begin
            if (hit_i[i] && !any_o) begin
                pick_o[i] = 1'b1;
                any_o     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mr_resp_route.sv
module mr_resp_route
    import mr_pkg::*;
#(
    parameter int unsigned N_RGN = 3,
    parameter logic [2*N_RGN-1:0] RGN_ACC = '0,
    parameter int unsigned LANE = LANE_RD
) (
    input  logic [N_RGN-1:0] pick_i,
    input  logic             any_i,
    input  logic             stb_i,
    input  logic [N_RGN-1:0] rgn_done_i,
    input  logic [N_RGN-1:0] rgn_err_i,
    input  mr_resp_t         fb_i,
    output mr_resp_t         resp_o,
    output logic [N_RGN-1:0] sel_o
);
    always_comb begin
        sel_o  = '0;
        resp_o = fb_i;
        if (any_i) begin
            resp_o = '0;
            for (int i = 0; i < N_RGN; i++) begin
                if (pick_i[i]) begin
                    if (RGN_ACC[2*i + LANE]) begin
                        sel_o[i]    = 1'b1;
                        resp_o.done = rgn_done_i[i];
                        resp_o.err  = rgn_err_i[i];
                    end else begin
                        resp_o.done = 1'b0;
                        resp_o.err  = stb_i;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mr_data_mux.sv
module mr_data_mux #(
    parameter int unsigned N_RGN  = 3,
    parameter int unsigned DATA_W = 32,
    parameter logic [2*N_RGN-1:0] RGN_ACC = '0
) (
    input  logic [N_RGN-1:0]        pick_i,
    input  logic                    any_i,
    input  logic [N_RGN*DATA_W-1:0] rgn_data_i,
    input  logic [DATA_W-1:0]       fb_data_i,
    output logic [DATA_W-1:0]       data_o
);
    always_comb begin
        data_o = any_i ? '0 : fb_data_i;
        for (int i = 0; i < N_RGN; i++) begin
            if (pick_i[i] && RGN_ACC[2*i])
                data_o = rgn_data_i[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/mem_region_router.sv
module mem_region_router
    import mr_pkg::*;
#(
    parameter int unsigned N_RGN  = 3,
    parameter int unsigned WA_W   = 10,
    parameter int unsigned DATA_W = 32,
    parameter logic [N_RGN*WA_W-1:0] RGN_LO  = {10'd256, 10'd96, 10'd64},
    parameter logic [N_RGN*WA_W-1:0] RGN_HI  = {10'd271, 10'd159, 10'd127},
    parameter logic [2*N_RGN-1:0]    RGN_ACC = {ACC_WO, ACC_RO, ACC_RW},
    localparam int unsigned MEM_AW = max_span()
) (
    input  logic [WA_W-1:0]         rd_word_i,
    input  logic                    rd_stb_i,
    input  logic [WA_W-1:0]         wr_word_i,
    input  logic                    wr_stb_i,
    input  logic [N_RGN*DATA_W-1:0] rgn_rd_data_i,
    input  logic [N_RGN-1:0]        rgn_rd_done_i,
    input  logic [N_RGN-1:0]        rgn_rd_err_i,
    input  logic [N_RGN-1:0]        rgn_wr_done_i,
    input  logic [N_RGN-1:0]        rgn_wr_err_i,
    input  logic [DATA_W-1:0]       reg_rd_data_i,
    input  logic                    reg_rd_done_i,
    input  logic                    reg_rd_err_i,
    input  logic                    reg_wr_done_i,
    input  logic                    reg_wr_err_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    rd_done_o,
    output logic                    rd_err_o,
    output logic                    wr_done_o,
    output logic                    wr_err_o,
    output logic [N_RGN-1:0]        rgn_rd_sel_o,
    output logic [N_RGN-1:0]        rgn_wr_sel_o,
    output logic [N_RGN*MEM_AW-1:0] rgn_rd_addr_o,
    output logic [N_RGN*MEM_AW-1:0] rgn_wr_addr_o
);
    function automatic int unsigned max_span();
        int unsigned m;
        m = 1;
        for (int i = 0; i < N_RGN; i++) begin
            if (span_bits(int'(RGN_LO[i*WA_W +: WA_W]), int'(RGN_HI[i*WA_W +: WA_W])) > m)
                m = span_bits(int'(RGN_LO[i*WA_W +: WA_W]), int'(RGN_HI[i*WA_W +: WA_W]));
        end
        return m;
    endfunction

    logic [N_RGN-1:0] rd_hit, wr_hit, rd_pick, wr_pick;
    logic             rd_any, wr_any;
    mr_resp_t         rd_fb, wr_fb, rd_resp, wr_resp;

    assign rd_fb = '{done: reg_rd_done_i, err: reg_rd_err_i};
    assign wr_fb = '{done: reg_wr_done_i, err: reg_wr_err_i};

    // Read side: decoded from the read word only.
    mr_range_match #(.N_RGN(N_RGN), .WA_W(WA_W), .RGN_LO(RGN_LO), .RGN_HI(RGN_HI))
        u_rd_match (.word_i(rd_word_i), .hit_o(rd_hit));
    mr_first_pick #(.N_RGN(N_RGN))
        u_rd_pick (.hit_i(rd_hit), .pick_o(rd_pick), .any_o(rd_any));
    mr_resp_route #(.N_RGN(N_RGN), .RGN_ACC(RGN_ACC), .LANE(LANE_RD))
        u_rd_resp (.pick_i(rd_pick), .any_i(rd_any), .stb_i(rd_stb_i),
                   .rgn_done_i(rgn_rd_done_i), .rgn_err_i(rgn_rd_err_i),
                   .fb_i(rd_fb), .resp_o(rd_resp), .sel_o(rgn_rd_sel_o));
    mr_data_mux #(.N_RGN(N_RGN), .DATA_W(DATA_W), .RGN_ACC(RGN_ACC))
        u_rd_data (.pick_i(rd_pick), .any_i(rd_any), .rgn_data_i(rgn_rd_data_i),
                   .fb_data_i(reg_rd_data_i), .data_o(rd_data_o));

    // Write side: decoded from the write word only.
    mr_range_match #(.N_RGN(N_RGN), .WA_W(WA_W), .RGN_LO(RGN_LO), .RGN_HI(RGN_HI))
        u_wr_match (.word_i(wr_word_i), .hit_o(wr_hit));
    mr_first_pick #(.N_RGN(N_RGN))
        u_wr_pick (.hit_i(wr_hit), .pick_o(wr_pick), .any_o(wr_any));
    mr_resp_route #(.N_RGN(N_RGN), .RGN_ACC(RGN_ACC), .LANE(LANE_WR))
        u_wr_resp (.pick_i(wr_pick), .any_i(wr_any), .stb_i(wr_stb_i),
                   .rgn_done_i(rgn_wr_done_i), .rgn_err_i(rgn_wr_err_i),
                   .fb_i(wr_fb), .resp_o(wr_resp), .sel_o(rgn_wr_sel_o));

    assign rd_done_o = rd_resp.done;
    assign rd_err_o  = rd_resp.err;
    assign wr_done_o = wr_resp.done;
    assign wr_err_o  = wr_resp.err;

    // Local memory addresses: low bits of the word, sized per region.
    for (genvar g = 0; g < N_RGN; g++) begin : g_addr
        localparam int unsigned AW_G =
            span_bits(int'(RGN_LO[g*WA_W +: WA_W]), int'(RGN_HI[g*WA_W +: WA_W]));
        if (AW_G < MEM_AW) begin : g_pad
            assign rgn_rd_addr_o[g*MEM_AW +: MEM_AW] = {{(MEM_AW-AW_G){1'b0}}, rd_word_i[AW_G-1:0]};
            assign rgn_wr_addr_o[g*MEM_AW +: MEM_AW] = {{(MEM_AW-AW_G){1'b0}}, wr_word_i[AW_G-1:0]};
        end else begin : g_full
            assign rgn_rd_addr_o[g*MEM_AW +: MEM_AW] = rd_word_i[MEM_AW-1:0];
            assign rgn_wr_addr_o[g*MEM_AW +: MEM_AW] = wr_word_i[MEM_AW-1:0];
        end
    end
endmodule

// File: rtl/mem_region_router_chk.sv
module mem_region_router_chk #(
    parameter int unsigned N_RGN  = 3,
    parameter int unsigned WA_W   = 10,
    parameter int unsigned DATA_W = 32,
    parameter logic [N_RGN*WA_W-1:0] RGN_LO  = '0,
    parameter logic [N_RGN*WA_W-1:0] RGN_HI  = '0,
    parameter logic [2*N_RGN-1:0]    RGN_ACC = '0
) (
    input logic [WA_W-1:0]         rd_word_i,
    input logic                    rd_stb_i,
    input logic [WA_W-1:0]         wr_word_i,
    input logic                    wr_stb_i,
    input logic [N_RGN-1:0]        rgn_rd_done_i,
    input logic [N_RGN-1:0]        rgn_rd_err_i,
    input logic [N_RGN-1:0]        rgn_wr_done_i,
    input logic [N_RGN-1:0]        rgn_wr_err_i,
    input logic [DATA_W-1:0]       reg_rd_data_i,
    input logic                    reg_rd_done_i,
    input logic                    reg_rd_err_i,
    input logic                    reg_wr_done_i,
    input logic                    reg_wr_err_i,
    input logic [DATA_W-1:0]       rd_data_o,
    input logic                    rd_done_o,
    input logic                    rd_err_o,
    input logic                    wr_done_o,
    input logic                    wr_err_o,
    input logic [N_RGN-1:0]        rgn_rd_sel_o,
    input logic [N_RGN-1:0]        rgn_wr_sel_o
);
    function automatic logic covered(logic [WA_W-1:0] w);
        logic c;
        c = 1'b0;
        for (int i = 0; i < N_RGN; i++)
            if (w >= RGN_LO[i*WA_W +: WA_W] && w <= RGN_HI[i*WA_W +: WA_W]) c = 1'b1;
        return c;
    endfunction

    always_comb begin
        if (!$isunknown({rd_word_i, wr_word_i, rd_stb_i, wr_stb_i, rgn_rd_sel_o, rgn_wr_sel_o})) begin
            assert_rd_sel_onehot_R3: assert ($onehot0(rgn_rd_sel_o));
            assert_wr_sel_onehot_R3: assert ($onehot0(rgn_wr_sel_o));
            for (int i = 0; i < N_RGN; i++) begin
                if (rgn_rd_sel_o[i]) begin
                    assert_rd_sel_in_window_R1: assert (rd_word_i >= RGN_LO[i*WA_W +: WA_W]
                                                        && rd_word_i <= RGN_HI[i*WA_W +: WA_W]);
                    assert_rd_pass_R4: assert (rd_done_o == rgn_rd_done_i[i] && rd_err_o == rgn_rd_err_i[i]);
                end
                if (rgn_wr_sel_o[i]) begin
                    assert_wr_sel_in_window_R1: assert (wr_word_i >= RGN_LO[i*WA_W +: WA_W]
                                                        && wr_word_i <= RGN_HI[i*WA_W +: WA_W]);
                    assert_wr_pass_R6: assert (wr_done_o == rgn_wr_done_i[i] && wr_err_o == rgn_wr_err_i[i]);
                end
            end
            if (covered(rd_word_i) && rgn_rd_sel_o == '0)
                assert_rd_denied_R5: assert (rd_data_o == '0 && !rd_done_o && rd_err_o == rd_stb_i);
            if (covered(wr_word_i) && rgn_wr_sel_o == '0)
                assert_wr_denied_R7: assert (!wr_done_o && wr_err_o == wr_stb_i);
            if (!covered(rd_word_i))
                assert_rd_fallback_R8: assert (rgn_rd_sel_o == '0 && rd_data_o == reg_rd_data_i
                                               && rd_done_o == reg_rd_done_i && rd_err_o == reg_rd_err_i);
            if (!covered(wr_word_i))
                assert_wr_fallback_R8: assert (rgn_wr_sel_o == '0 && wr_done_o == reg_wr_done_i
                                               && wr_err_o == reg_wr_err_i);
        end
    end
endmodule

bind mem_region_router mem_region_router_chk #(
    .N_RGN(N_RGN), .WA_W(WA_W), .DATA_W(DATA_W),
    .RGN_LO(RGN_LO), .RGN_HI(RGN_HI), .RGN_ACC(RGN_ACC)
) u_chk (
    .rd_word_i(rd_word_i), .rd_stb_i(rd_stb_i), .wr_word_i(wr_word_i), .wr_stb_i(wr_stb_i),
    .rgn_rd_done_i(rgn_rd_done_i), .rgn_rd_err_i(rgn_rd_err_i),
    .rgn_wr_done_i(rgn_wr_done_i), .rgn_wr_err_i(rgn_wr_err_i),
    .reg_rd_data_i(reg_rd_data_i), .reg_rd_done_i(reg_rd_done_i), .reg_rd_err_i(reg_rd_err_i),
    .reg_wr_done_i(reg_wr_done_i), .reg_wr_err_i(reg_wr_err_i),
    .rd_data_o(rd_data_o), .rd_done_o(rd_done_o), .rd_err_o(rd_err_o),
    .wr_done_o(wr_done_o), .wr_err_o(wr_err_o),
    .rgn_rd_sel_o(rgn_rd_sel_o), .rgn_wr_sel_o(rgn_wr_sel_o)
);

// File: tb/tb_mem_region_router.sv
module tb_mem_region_router;
    localparam int N = 3;
    localparam int WA = 10;
    localparam int DW = 32;
    localparam int MAW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [WA-1:0]     rd_word, wr_word;
    logic              rd_stb, wr_stb;
    logic [N*DW-1:0]   rgn_rd_data;
    logic [N-1:0]      rgn_rd_done, rgn_rd_err, rgn_wr_done, rgn_wr_err;
    logic [DW-1:0]     reg_rd_data;
    logic              reg_rd_done, reg_rd_err, reg_wr_done, reg_wr_err;
    logic [DW-1:0]     rd_data;
    logic              rd_done, rd_err, wr_done, wr_err;
    logic [N-1:0]      rd_sel, wr_sel;
    logic [N*MAW-1:0]  rd_addr, wr_addr;

    int checks = 0;
    int fails  = 0;

    mem_region_router dut (
        .rd_word_i(rd_word), .rd_stb_i(rd_stb), .wr_word_i(wr_word), .wr_stb_i(wr_stb),
        .rgn_rd_data_i(rgn_rd_data), .rgn_rd_done_i(rgn_rd_done), .rgn_rd_err_i(rgn_rd_err),
        .rgn_wr_done_i(rgn_wr_done), .rgn_wr_err_i(rgn_wr_err),
        .reg_rd_data_i(reg_rd_data), .reg_rd_done_i(reg_rd_done), .reg_rd_err_i(reg_rd_err),
        .reg_wr_done_i(reg_wr_done), .reg_wr_err_i(reg_wr_err),
        .rd_data_o(rd_data), .rd_done_o(rd_done), .rd_err_o(rd_err),
        .wr_done_o(wr_done), .wr_err_o(wr_err),
        .rgn_rd_sel_o(rd_sel), .rgn_wr_sel_o(wr_sel),
        .rgn_rd_addr_o(rd_addr), .rgn_wr_addr_o(wr_addr)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (rd_word=%0d wr_word=%0d)", req, act, exp, rd_word, wr_word);
        end
    endtask

    // Lowest region whose inclusive window holds w, or -1.
    function automatic int first_hit(int w);
        if (w >= 64 && w <= 127) return 0;
        if (w >= 96 && w <= 159) return 1;
        if (w >= 256 && w <= 271) return 2;
        return -1;
    endfunction

    function automatic bit can_rd(int r); return (r == 0) || (r == 1); endfunction
    function automatic bit can_wr(int r); return (r == 0) || (r == 2); endfunction

    task automatic drive(int rw, int ww);
        rd_word = WA'(rw);
        wr_word = WA'(ww);
        rd_stb  = rw[0] ^ rw[4];
        wr_stb  = ww[1] ^ ww[5];
        for (int i = 0; i < N; i++) rgn_rd_data[i*DW +: DW] = ((i + 1) << 24) | rw;
        rgn_rd_done = rw[2:0];
        rgn_rd_err  = rw[5:3];
        rgn_wr_done = ww[2:0] ^ ww[9:7];
        rgn_wr_err  = ww[5:3] ^ 3'b010;
        reg_rd_data = 32'hFEED0000 | rw;
        reg_rd_done = rw[0];
        reg_rd_err  = rw[1];
        reg_wr_done = ww[2];
        reg_wr_err  = ww[3];
    endtask

    task automatic check_all(int rw, int ww);
        int r, q;
        logic [DW-1:0] ed;
        logic edn, eer;
        logic [N*MAW-1:0] ea;
        r = first_hit(rw);
        q = first_hit(ww);
        // read side
        if (r < 0) begin
            ed = reg_rd_data; edn = reg_rd_done; eer = reg_rd_err;
            chk("R8 rd_data", rd_data, ed);
            chk("R8 rd_flags", {rd_done, rd_err}, {edn, eer});
        end else if (can_rd(r)) begin
            chk("R4 rd_data", rd_data, ((r + 1) << 24) | rw);
            chk("R4 rd_flags", {rd_done, rd_err}, {rgn_rd_done[r], rgn_rd_err[r]});
        end else begin
            chk("R5 rd_data", rd_data, 0);
            chk("R5 rd_flags", {rd_done, rd_err}, {1'b0, rd_stb});
        end
        chk("R3 rd_sel", rd_sel, (r >= 0 && can_rd(r)) ? (1 << r) : 0);
        // write side
        if (q < 0)
            chk("R8 wr_flags", {wr_done, wr_err}, {reg_wr_done, reg_wr_err});
        else if (can_wr(q))
            chk("R6 wr_flags", {wr_done, wr_err}, {rgn_wr_done[q], rgn_wr_err[q]});
        else
            chk("R7 wr_flags", {wr_done, wr_err}, {1'b0, wr_stb});
        chk("R3 wr_sel", wr_sel, (q >= 0 && can_wr(q)) ? (1 << q) : 0);
        // local addresses
        ea = {6'(rw % 16), 6'(rw % 64), 6'(rw % 64)};
        chk("R10 rd_addr", rd_addr, ea);
        ea = {6'(ww % 16), 6'(ww % 64), 6'(ww % 64)};
        chk("R10 wr_addr", wr_addr, ea);
    endtask

    initial begin
        drive(0, 0);
        rgn_rd_done = '0; rgn_rd_err = '0; rgn_wr_done = '0; rgn_wr_err = '0;
        reg_rd_done = 0; reg_rd_err = 0; reg_wr_done = 0; reg_wr_err = 0;
        reg_rd_data = '0; rd_stb = 0; wr_stb = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset-state check: idle inputs, address 0 is unmapped
        chk("R8 idle rd", {rd_data, rd_done, rd_err}, 0);
        chk("R3 idle sel", {rd_sel, wr_sel}, 0);

        // R1 boundary words of region 0 and 2
        @(posedge clk); drive(63, 255); @(negedge clk);
        chk("R1 below lo", {rd_sel, wr_sel}, 0);
        @(posedge clk); drive(64, 256); @(negedge clk);
        chk("R1 at lo", {rd_sel, wr_sel}, {3'b001, 3'b100});
        @(posedge clk); drive(127, 271); @(negedge clk);
        chk("R1 at hi", {rd_sel, wr_sel}, {3'b001, 3'b100});
        @(posedge clk); drive(160, 272); @(negedge clk);
        chk("R1 above hi", {rd_sel, wr_sel}, 0);
        // R2 overlap: region 0 beats region 1
        @(posedge clk); drive(96, 100); @(negedge clk);
        chk("R2 overlap rd", rd_sel, 3'b001);
        chk("R2 overlap wr", wr_sel, 3'b001);
        @(posedge clk); drive(128, 128); @(negedge clk);
        chk("R2 after overlap", {rd_sel, wr_sel}, {3'b010, 3'b000});
        // R9 independent decode of the two sides
        @(posedge clk); drive(70, 300); @(negedge clk);
        chk("R9 split rd", rd_sel, 3'b001);
        chk("R9 split wr", wr_sel, 3'b000);
        @(posedge clk); drive(300, 260); @(negedge clk);
        chk("R9 split swap", {rd_sel, wr_sel}, {3'b000, 3'b100});

        // full sweep, write word offset from read word
        for (int w = 0; w < 1024; w++) begin
            @(posedge clk);
            drive(w, (w + 160) % 1024);
            @(negedge clk);
            check_all(w, (w + 160) % 1024);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule